// File: doc/BRIEF.md
# Power-Down Clock Stop Sequencer

This block controls the way a clock generator enters and leaves its low-power state. An active-low power-down request arrives asynchronously. It is synchronized into the internal clock domain before the block acts on it. On entry, every output clock gate is told to stop. The gate enables change only on a falling edge of the internal clock, so each gated clock parks low on a clean edge. The block then waits until every gate reports that its output is held low. Some gates, such as the reference clock gate, may need several of their own cycles to report this. Only after that does the block drop the VCO enable, and after a further gap it drops the crystal oscillator enable.

On exit the order is reversed. The oscillator is enabled first and given a fixed start time. Then the VCO enable is raised and the block waits for the PLL lock indication, or for a settle timeout if lock does not arrive. When either occurs, all output gates reopen together on a falling edge. The settle timer bounds the restart latency.

If the request returns while the block is restarting, the block goes straight back to shutting the VCO and oscillator down. The outputs stay parked throughout. A release of the request during a stop sequence does not abort it: the sequence completes and the restart follows.

Top module: `pwrdn_sequencer`

## Requirements
- R1: While reset is high and just after it, every gate enable, the VCO enable and the oscillator enable are low. The block starts in the fully powered-down condition.
- R2: The request passes through SYNC_STAGES flip-flops (default 2) and then the state register. With the default, a fall of `pwr_dn_n` between two rising edges turns the gate enables off on the falling edge that follows the third rising edge after the fall.
- R3: `gate_run` bits change only on falling clock edges, and all bits always hold the same value.
- R4: After the gates close, the VCO enable stays high until two conditions hold: at least one full cycle has passed in the stop state, and every bit of `gate_stopped` is high on a rising edge. The VCO enable drops on that edge.
- R5: The VCO enable is low for VCO_GAP cycles before the oscillator enable drops.
- R6: In the powered-down condition, the gates, the VCO enable and the oscillator enable stay low for as long as the request stays asserted.
- R7: After the synchronized request releases, the oscillator enable rises. The VCO enable rises exactly OSC_WAIT cycles later.
- R8: If `pll_locked` is high on a rising edge while the block waits for lock, all gates reopen on the next falling edge. The gates are never open while the VCO enable is low.
- R9: Without lock, the gates reopen after SETTLE cycles of waiting with the VCO enabled.
- R10: A request that returns during the oscillator start or the lock wait drops the VCO enable at once, with the gates still closed. The oscillator enable follows VCO_GAP cycles later.
- R11: A request that returns once the gates have reopened runs the normal stop sequence.
- R12: A release of the request during the stop sequence does not abort it. The block reaches the powered-down condition and then restarts.
- R13: The VCO enable is never high while the oscillator enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock the output clocks are timed against |
| rst | input | 1 | Synchronous active-high reset |
| pwr_dn_n | input | 1 | Asynchronous power-down request, active low |
| gate_stopped | input | NUM_GROUPS | Per-group report from the clock gates that the output is held low |
| pll_locked | input | 1 | Lock indication from the PLLs |
| gate_run | output | NUM_GROUPS | Per-group output gate enable, updated on falling edges |
| vco_en | output | 1 | VCO enable |
| osc_en | output | 1 | Crystal oscillator enable |

## Verification
The bench goes after ordering hazards in both directions.

A slow reference-clock gate holds back its stop report, and the VCO must wait for it. A design that did not wait would kill the VCO under a still-running output. Lock is withheld to force the settle timeout, since a design without the timeout would hang with the outputs parked. The request is reasserted during oscillator start and during lock wait; a wrong design would reopen a gate or leave the VCO running with the oscillator off. The request is also released in the middle of the stop sequence, where a wrong design would stall or open the gates with the VCO down. Any gate edge away from a falling clock edge is flagged as a glitch.

// File: rtl/pwrdn_seq_pkg.sv
package pwrdn_seq_pkg;

    typedef enum logic [2:0] {
        ST_RUN        = 3'd0,
        ST_PARK       = 3'd1,
        ST_VCO_DOWN   = 3'd2,
        ST_ASLEEP     = 3'd3,
        ST_OSC_WARM   = 3'd4,
        ST_LOCK_WAIT  = 3'd5,
        ST_REOPEN     = 3'd6
    } seq_state_e;

    typedef struct packed {
        logic osc_en;
        logic vco_en;
        logic gate_req;
    } seq_ctl_t;

    function automatic seq_ctl_t ctl_of(seq_state_e s);
        seq_ctl_t c;
        c = '{osc_en: 1'b0, vco_en: 1'b0, gate_req: 1'b0};
        case (s)
            ST_RUN, ST_REOPEN:          c = '{osc_en: 1'b1, vco_en: 1'b1, gate_req: 1'b1};
            ST_PARK, ST_LOCK_WAIT:      c = '{osc_en: 1'b1, vco_en: 1'b1, gate_req: 1'b0};
            ST_VCO_DOWN, ST_OSC_WARM:   c = '{osc_en: 1'b1, vco_en: 1'b0, gate_req: 1'b0};
            default:                    c = '{osc_en: 1'b0, vco_en: 1'b0, gate_req: 1'b0};
        endcase
        return c;
    endfunction

    function automatic int unsigned max4(int unsigned a, int unsigned b,
                                         int unsigned c, int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/pwrdn_seq_sync.sv
module pwrdn_seq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_n,
    output logic req
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= async_n;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign req = ~chain[STAGES-1];
endmodule

// File: rtl/pwrdn_seq_timer.sv
module pwrdn_seq_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic [CW-1:0] limit,
    output logic [CW-1:0] count,
    output logic          expired
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr)        cnt_q <= '0;
        else if (cnt_q != '1)  cnt_q <= cnt_q + 1'b1;
    end

    assign count   = cnt_q;
    assign expired = ({1'b0, cnt_q} + 1'b1) >= {1'b0, limit};
endmodule

// File: rtl/pwrdn_seq_fsm.sv
module pwrdn_seq_fsm
    import pwrdn_seq_pkg::*;
#(
    parameter int OSC_WAIT = 8,
    parameter int SETTLE   = 64,
    parameter int VCO_GAP  = 2,
    parameter int CW       = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pd_req,
    input  logic          all_stopped,
    input  logic          pll_locked,
    input  logic          tmr_expired,
    input  logic [CW-1:0] tmr_count,
    output logic          tmr_clr,
    output logic [CW-1:0] tmr_limit,
    output seq_ctl_t      ctl
);
    seq_state_e state_q, state_d;
    seq_ctl_t   ctl_q;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_RUN:       if (pd_req) state_d = ST_PARK;
            ST_PARK:      if (tmr_expired && all_stopped) state_d = ST_VCO_DOWN;
            ST_VCO_DOWN:  if (tmr_expired) state_d = ST_ASLEEP;
            ST_ASLEEP:    if (!pd_req) state_d = ST_OSC_WARM;
            ST_OSC_WARM:  if (pd_req) state_d = ST_VCO_DOWN;
                          else if (tmr_expired) state_d = ST_LOCK_WAIT;
            ST_LOCK_WAIT: if (pd_req) state_d = ST_VCO_DOWN;
                          else if (pll_locked || tmr_expired) state_d = ST_REOPEN;
            ST_REOPEN:    state_d = pd_req ? ST_PARK : ST_RUN;
            default:      state_d = ST_ASLEEP;
        endcase
    end

    always_comb begin
        case (state_q)
            ST_PARK:      tmr_limit = CW'(2);
            ST_VCO_DOWN:  tmr_limit = CW'(VCO_GAP);
            ST_OSC_WARM:  tmr_limit = CW'(OSC_WAIT);
            ST_LOCK_WAIT: tmr_limit = CW'(SETTLE);
            default:      tmr_limit = CW'(1);
        endcase
    end

    assign tmr_clr = (state_d != state_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_ASLEEP;
            ctl_q   <= '{osc_en: 1'b0, vco_en: 1'b0, gate_req: 1'b0};
        end else begin
            state_q <= state_d;
            ctl_q   <= ctl_of(state_d);
        end
    end

    assign ctl = ctl_q;

    // R13: VCO only runs with the oscillator running
    p_vco_needs_osc_r13: assert property (@(posedge clk) disable iff (rst)
        ctl_q.vco_en |-> ctl_q.osc_en);

    // R5: oscillator drops only after the VCO was already down
    p_osc_after_vco_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(ctl_q.osc_en) |-> !$past(ctl_q.vco_en));

    // R4: leaving the park state requires every gate to report stopped
    p_park_exit_ack_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_VCO_DOWN && $past(state_q == ST_PARK)) |-> $past(all_stopped));

    // R9: the lock wait is bounded by the settle window
    p_settle_bound_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOCK_WAIT) |-> (tmr_count < CW'(SETTLE)));
endmodule

// File: rtl/pwrdn_seq_gates.sv
module pwrdn_seq_gates #(
    parameter int NUM_GROUPS = 7
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  gate_req,
    output logic [NUM_GROUPS-1:0] gate_run
);
    generate
        for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
            always_ff @(negedge clk) begin
                if (rst) gate_run[g] <= 1'b0;
                else     gate_run[g] <= gate_req;
            end
        end
    endgenerate

    // R3: all groups open and close together
    p_groups_together_r3: assert property (@(posedge clk) disable iff (rst)
        (gate_run == '0) || (gate_run == '1));
endmodule

// File: rtl/pwrdn_sequencer.sv
module pwrdn_sequencer
    import pwrdn_seq_pkg::*;
#(
    parameter int NUM_GROUPS  = 7,
    parameter int SYNC_STAGES = 2,
    parameter int OSC_WAIT    = 8,
    parameter int SETTLE      = 64,
    parameter int VCO_GAP     = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  pwr_dn_n,
    input  logic [NUM_GROUPS-1:0] gate_stopped,
    input  logic                  pll_locked,
    output logic [NUM_GROUPS-1:0] gate_run,
    output logic                  vco_en,
    output logic                  osc_en
);
    localparam int unsigned MAX_LIMIT = max4(OSC_WAIT, SETTLE, VCO_GAP, 2);
    localparam int CW = $clog2(MAX_LIMIT + 1) + 1;

    logic          pd_req;
    logic          tmr_clr;
    logic          tmr_expired;
    logic [CW-1:0] tmr_limit;
    logic [CW-1:0] tmr_count;
    seq_ctl_t      ctl;

    pwrdn_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_n (pwr_dn_n),
        .req     (pd_req)
    );

    pwrdn_seq_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clr     (tmr_clr),
        .limit   (tmr_limit),
        .count   (tmr_count),
        .expired (tmr_expired)
    );

    pwrdn_seq_fsm #(
        .OSC_WAIT (OSC_WAIT),
        .SETTLE   (SETTLE),
        .VCO_GAP  (VCO_GAP),
        .CW       (CW)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .pd_req      (pd_req),
        .all_stopped (&gate_stopped),
        .pll_locked  (pll_locked),
        .tmr_expired (tmr_expired),
        .tmr_count   (tmr_count),
        .tmr_clr     (tmr_clr),
        .tmr_limit   (tmr_limit),
        .ctl         (ctl)
    );

    pwrdn_seq_gates #(.NUM_GROUPS(NUM_GROUPS)) u_gates (
        .clk      (clk),
        .rst      (rst),
        .gate_req (ctl.gate_req),
        .gate_run (gate_run)
    );

    assign vco_en = ctl.vco_en;
    assign osc_en = ctl.osc_en;

    // R8: no gate is open while the VCO is off
    p_open_needs_vco_r8: assert property (@(posedge clk) disable iff (rst)
        (|gate_run) |-> vco_en);

    // R4: the VCO goes down only with every gate closed
    p_vco_off_gated_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(vco_en) |-> (gate_run == '0));
endmodule

// File: tb/pwrdn_sequencer_test.sv
module pwrdn_sequencer_test;
    localparam int NG       = 7;
    localparam int OSC_WAIT = 5;
    localparam int SETTLE   = 12;
    localparam int VCO_GAP  = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pwr_dn_n = 1'b1;
    logic [NG-1:0] gate_stopped = '0;
    logic          pll_locked = 1'b0;
    logic [NG-1:0] gate_run;
    logic          vco_en, osc_en;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  cmp_en = 0;
    bit  done = 0;
    string cur_req = "R1";

    // environment knobs
    bit lock_mode = 0;
    int lock_after = 3;
    int lock_cnt = 0;
    int ack_cnt [NG];

    // reference model state: 0 run 1 park 2 vco-down 3 asleep 4 osc-warm 5 lock-wait 6 reopen
    int m_st = 3;
    int dwell = 0;
    int nx;
    bit s1 = 0, s2 = 0, req;

    always #10 clk = ~clk;

    pwrdn_sequencer #(
        .NUM_GROUPS (NG),
        .SYNC_STAGES(2),
        .OSC_WAIT   (OSC_WAIT),
        .SETTLE     (SETTLE),
        .VCO_GAP    (VCO_GAP)
    ) uut (
        .clk          (clk),
        .rst          (rst),
        .pwr_dn_n     (pwr_dn_n),
        .gate_stopped (gate_stopped),
        .pll_locked   (pll_locked),
        .gate_run     (gate_run),
        .vco_en       (vco_en),
        .osc_en       (osc_en)
    );

    function automatic int ack_delay(int g);
        if (g == 5) return 3;      // reference-clock group: slow to park
        if (g == 6) return 2;
        return 1;
    endfunction

    // clock-gate and PLL environment, updated just after each falling edge
    always @(negedge clk) begin
        #2;
        for (int g = 0; g < NG; g++) begin
            if (gate_run[g] === 1'b1) ack_cnt[g] = 0;
            else if (ack_cnt[g] < 100) ack_cnt[g] = ack_cnt[g] + 1;
            gate_stopped[g] = (ack_cnt[g] >= ack_delay(g));
        end
        if (vco_en !== 1'b1) lock_cnt = 0;
        else lock_cnt = lock_cnt + 1;
        pll_locked = lock_mode && (lock_cnt >= lock_after);
    end

    // behavioural reference model
    always @(posedge clk) begin
        if (rst) begin
            m_st = 3; dwell = 0; s1 = 0; s2 = 0;
        end else begin
            req = !s2;
            nx = m_st;
            case (m_st)
                0: if (req) nx = 1;
                1: if (dwell >= 1 && (&gate_stopped)) nx = 2;
                2: if (dwell >= VCO_GAP - 1) nx = 3;
                3: if (!req) nx = 4;
                4: if (req) nx = 2; else if (dwell >= OSC_WAIT - 1) nx = 5;
                5: if (req) nx = 2; else if (pll_locked || dwell >= SETTLE - 1) nx = 6;
                default: nx = req ? 1 : 0;
            endcase
            dwell = (nx != m_st) ? 0 : dwell + 1;
            m_st = nx;
            s2 = s1;
            s1 = pwr_dn_n;
        end
    end

    task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // per-cycle comparison just before each rising edge
    always @(negedge clk) begin
        #8;
        if (cmp_en && !done) begin
            chk(cur_req, "vco_en", 32'(vco_en),
                32'(m_st == 0 || m_st == 1 || m_st == 5 || m_st == 6));
            chk(cur_req, "osc_en", 32'(osc_en), 32'(m_st != 3));
            chk(cur_req, "gate_run", 32'(gate_run),
                (m_st == 0 || m_st == 6) ? 32'((1 << NG) - 1) : 32'd0);
        end
    end

    // R3: gate enables may only move on a falling clock edge
    always @(gate_run) begin
        if (cmp_en && !done && clk !== 1'b0) begin
            n_cmp++; n_bad++;
            $display("FAIL R3 gate_run changed off a falling edge: actual %0h expected stable", gate_run);
        end
    end

    task automatic cycles(int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic drive_pd(logic v);
        @(negedge clk); #3;
        pwr_dn_n = v;
    endtask

    task automatic finish_up();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        for (int g = 0; g < NG; g++) ack_cnt[g] = 0;
        // R1: reset state
        cur_req = "R1";
        cycles(3);
        @(negedge clk); #8;
        cmp_en = 1;
        chk("R1", "reset gate_run", 32'(gate_run), 32'd0);
        chk("R1", "reset vco_en", 32'(vco_en), 32'd0);
        chk("R1", "reset osc_en", 32'(osc_en), 32'd0);
        @(negedge clk); rst = 0;

        // R7 / R8: start-up with early lock
        cur_req = "R7";
        lock_mode = 1; lock_after = 3;
        cycles(2 + OSC_WAIT + 1);
        cur_req = "R8";
        cycles(20);
        chk("R8", "running after lock", 32'(gate_run), 32'((1 << NG) - 1));

        // R2: synchronizer latency of the stop, then R4/R5/R6 sequence
        cur_req = "R2";
        drive_pd(1'b0);
        cycles(3);
        #1;
        chk("R2", "gates still open after third edge", 32'(gate_run), 32'((1 << NG) - 1));
        @(negedge clk); #2;
        chk("R2", "gates closed at following falling edge", 32'(gate_run), 32'd0);
        cur_req = "R4";
        cycles(8);
        cur_req = "R6";
        cycles(20);
        chk("R6", "asleep vco_en", 32'(vco_en), 32'd0);
        chk("R6", "asleep osc_en", 32'(osc_en), 32'd0);

        // R9: restart without lock
        cur_req = "R9";
        lock_mode = 0;
        drive_pd(1'b1);
        cycles(2 + OSC_WAIT + SETTLE + 6);
        chk("R9", "open after timeout", 32'(gate_run), 32'((1 << NG) - 1));

        // R12: release in the middle of the stop sequence
        cur_req = "R12";
        lock_mode = 1;
        drive_pd(1'b0);
        cycles(4);
        drive_pd(1'b1);
        cycles(40);
        chk("R12", "restarted after aborted release", 32'(gate_run), 32'((1 << NG) - 1));

        // R10: reassert during oscillator warm-up
        cur_req = "R10";
        drive_pd(1'b0);
        cycles(30);
        drive_pd(1'b1);
        cycles(4);
        drive_pd(1'b0);
        cycles(20);
        chk("R10", "down again after warm-up abort", 32'(osc_en), 32'd0);

        // R10: reassert during lock wait
        lock_mode = 0;
        drive_pd(1'b1);
        cycles(2 + OSC_WAIT + 3);
        drive_pd(1'b0);
        cycles(20);
        chk("R10", "gates never opened", 32'(gate_run), 32'd0);

        // R11: reassert right after the gates reopen
        cur_req = "R11";
        lock_mode = 1; lock_after = 1;
        drive_pd(1'b1);
        while (gate_run !== '1) @(negedge clk);
        drive_pd(1'b0);
        cycles(30);
        chk("R11", "stopped again", 32'(vco_en), 32'd0);

        // R13 checked every cycle; final restart
        cur_req = "R13";
        drive_pd(1'b1);
        cycles(30);
        chk("R13", "final run osc_en", 32'(osc_en), 32'd1);
        finish_up();
    end
endmodule